// File: doc/BRIEF.md
# Multiplexed Parallel Register Bus Slave

This block is the target side of an 8-bit host bus on which addresses and data travel over the same lines. A dedicated phase input picks the meaning of each cycle: high marks an address cycle, low a data cycle. The host writes a register address in an address cycle, then performs one data-cycle read or write to that register. Chip select, read strobe and write strobe are active low. The block answers every access by pulling an active-low ready output low once it has taken write data or has read data on the bus. It releases ready when the host lets go of the strobes.

Behind the bus sits a small register map. It holds plain control registers (a second bus-control register whose bits 5:4 enable two transport-stream outputs, a bus-control register, card and PID address pairs, and two stream clock dividers). Two data ports are forwarded to attached engines, the card-access engine and the PID bitmap engine, as single-cycle strobes. The map also holds a read-only revision value and the interrupt control register. An engine event raises an active-low interrupt once interrupt generation is enabled, and a host read of the interrupt register acknowledges it. The host strobes are sampled through a synchronizer, so host timing only needs to meet the handshake and not the clock.

Top module: `mxbus_slave`

## Requirements
- R1: While reset is applied, rdy_n and irq_n are 1, bus_oe is 0 and all register outputs (card_addr_o, pid_addr_o, bus_ctl_o, ctl2_o, ts_en_o, div_a_o, div_b_o) are 0.
- R2: An access with cs_n=0, wr_n=0 and ab_sel=1 latches bus_in as the register address and changes no register. The address stays selected for every following data cycle until the next address cycle.
- R3: With ab_sel=0, a write with cs_n=0 and wr_n=0 stores bus_in in the selected register. A read with rd_n=0 puts the register's value on bus_out. The read/write addresses are 0x00 interrupt control, 0x01 bus control 2, 0x04/0x05 card address low/high (card_addr_o = {high, low}), 0x07 bus control, 0x08/0x09 PID address low/high (pid_addr_o = {high, low}), and 0x0C/0x0D stream A/B dividers.
- R4: A data write to 0x06 (card) or 0x0A (PID) produces exactly one single-cycle card_wr_o or pid_wr_o pulse, with the written byte on eng_wdata_o. A data read from those addresses returns card_rdata_i or pid_rdata_i and produces exactly one card_rd_o or pid_rd_o pulse. At most one of these four strobes is high in any cycle, however long the host holds its strobe.
- R5: A read of 0x0F returns the REVISION parameter, and writes to 0x0F change nothing.
- R6: Reads of undefined addresses (0x02, 0x03, 0x0B, 0x0E and all above 0x0F) return 0x00, and writes to them leave every register output unchanged.
- R7: rdy_n goes low no more than SYNC_STAGES+2 clocks after the strobes are asserted and stays low while they are held. It returns high no more than SYNC_STAGES+2 clocks after release. Each strobe assertion performs one access only.
- R8: A one-cycle pulse on evt_i makes an interrupt pending, with irq_n = 0, only when interrupt-control bits 6 and 2 are both 1 (written value 0x44). With either bit clear the event is ignored.
- R9: A data read of 0x00 returns the stored control value with bit 0 replaced by the pending flag, and it clears the pending interrupt so that irq_n returns to 1. An event in the same cycle as the acknowledge keeps the interrupt pending.
- R10: ts_en_o equals bits 5:4 of bus control 2 (address 0x01).
- R11: bus_oe is 1 only while a data-phase read is being acknowledged (rdy_n = 0). It is 0 during address cycles and data writes.
- R12: While cs_n is 1, rd_n and wr_n are ignored: rdy_n stays 1 and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_in | input | BUS_W | Shared address/data lines from the host |
| bus_out | output | BUS_W | Read data toward the host |
| bus_oe | output | 1 | Drive enable for bus_out |
| ab_sel | input | 1 | Phase select: 1 address cycle, 0 data cycle |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rdy_n | output | 1 | Access complete, active low |
| irq_n | output | 1 | Interrupt request, active low |
| evt_i | input | 1 | Single-cycle interrupt event from the engines |
| card_addr_o | output | 2*BUS_W | Card access address {high, low} |
| card_wr_o | output | 1 | Card data write strobe |
| card_rd_o | output | 1 | Card data read strobe |
| card_rdata_i | input | BUS_W | Card engine read data |
| pid_addr_o | output | 2*BUS_W | PID bitmap address {high, low} |
| pid_wr_o | output | 1 | PID data write strobe |
| pid_rd_o | output | 1 | PID data read strobe |
| pid_rdata_i | input | BUS_W | PID engine read data |
| eng_wdata_o | output | BUS_W | Write data for both engines |
| bus_ctl_o | output | BUS_W | Bus control register |
| ctl2_o | output | BUS_W | Bus control 2 register |
| ts_en_o | output | 2 | Transport-stream output enables |
| div_a_o | output | BUS_W | Stream A clock divider |
| div_b_o | output | BUS_W | Stream B clock divider |

## Verification
The bench holds the strobes for several extra cycles on engine accesses. A design that acted on every cycle of a held strobe would then emit a burst of engine pulses instead of one. It runs data cycles back to back with no new address in between, which exposes a design that forgets or clears the latched address, and it checks that an address cycle leaves the register it names untouched. It fires engine events under partial and full interrupt enables, which catches a design that enables on a single bit. It then reads the interrupt register twice, so a design that fails to clear on acknowledge would report the pending bit a second time and hold irq_n low. It also drives write strobes with chip select high, writes to the revision and undefined addresses, and expects zero back from the holes, so a decoder that aliases or misses addresses shows up as changed outputs.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  // Register map; offsets are what the host software decodes.
  localparam logic [7:0] A_INTC = 8'h00;
  localparam logic [7:0] A_CTL2 = 8'h01;
  localparam logic [7:0] A_CADL = 8'h04;
  localparam logic [7:0] A_CADH = 8'h05;
  localparam logic [7:0] A_CDAT = 8'h06;
  localparam logic [7:0] A_BCTL = 8'h07;
  localparam logic [7:0] A_PADL = 8'h08;
  localparam logic [7:0] A_PADH = 8'h09;
  localparam logic [7:0] A_PDAT = 8'h0A;
  localparam logic [7:0] A_DIVA = 8'h0C;
  localparam logic [7:0] A_DIVB = 8'h0D;
  localparam logic [7:0] A_REV  = 8'h0F;

  // Plain read/write storage, index order is local to this block.
  localparam int NRW = 9;
  localparam int IX_INTC = 0;
  localparam int IX_CTL2 = 1;
  localparam int IX_CADL = 2;
  localparam int IX_CADH = 3;
  localparam int IX_BCTL = 4;
  localparam int IX_PADL = 5;
  localparam int IX_PADH = 6;
  localparam int IX_DIVA = 7;
  localparam int IX_DIVB = 8;
  localparam logic [7:0] RW_ADDR [NRW] = '{A_INTC, A_CTL2, A_CADL, A_CADH,
                                           A_BCTL, A_PADL, A_PADH, A_DIVA, A_DIVB};

  // Both bits must be set for interrupt generation.
  localparam logic [7:0] INT_EN_MASK = 8'h44;
  // Position of the two stream output enables inside bus control 2.
  localparam int TS_EN_LSB = 4;

  typedef enum logic {ST_IDLE = 1'b0, ST_ACK = 1'b1} hs_state_t;
endpackage

// File: rtl/mxb_sync.sv
module mxb_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mxb_handshake.sv
module mxb_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic s_cs_n,
  input  logic s_rd_n,
  input  logic s_wr_n,
  input  logic s_phase,
  output logic addr_wr,
  output logic data_wr,
  output logic data_rd,
  output logic rdy_n,
  output logic oe
);
  import mxb_pkg::*;

  hs_state_t st_q, st_d;
  logic      rd_q, rd_d;
  logic      active;

  always_comb begin
    active  = !s_cs_n && (!s_rd_n || !s_wr_n);
    st_d    = st_q;
    rd_d    = rd_q;
    addr_wr = 1'b0;
    data_wr = 1'b0;
    data_rd = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (active) begin
          // One action on entry; the strobe must be released before the next.
          st_d    = ST_ACK;
          data_rd = !s_rd_n && !s_phase;
          rd_d    = !s_rd_n && !s_phase;
          addr_wr = s_rd_n && s_phase;
          data_wr = s_rd_n && !s_phase;
        end
      end
      default: begin
        if (!active) begin
          st_d = ST_IDLE;
          rd_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rd_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rd_q <= rd_d;
    end
  end

  assign rdy_n = (st_q != ST_ACK);
  assign oe    = (st_q == ST_ACK) && rd_q;
endmodule

// File: rtl/mxb_irq.sv
module mxb_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic en,
  input  logic ack,
  output logic pending,
  output logic irq_n
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (ack)        pend_d = 1'b0;
    if (evt && en)  pend_d = 1'b1;   // a fresh event outranks the acknowledge
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;
  assign irq_n   = ~pend_q;
endmodule

// File: rtl/mxb_regfile.sv
module mxb_regfile #(
  parameter int               BUS_W    = 8,
  parameter logic [BUS_W-1:0] REVISION = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_wr,
  input  logic               data_wr,
  input  logic               data_rd,
  input  logic [BUS_W-1:0]   bus_d,
  input  logic               pending,
  input  logic [BUS_W-1:0]   card_rdata,
  input  logic [BUS_W-1:0]   pid_rdata,
  output logic [BUS_W-1:0]   rdata,
  output logic               irq_ack,
  output logic               irq_en,
  output logic [2*BUS_W-1:0] card_addr,
  output logic [2*BUS_W-1:0] pid_addr,
  output logic               card_wr,
  output logic               card_rd,
  output logic               pid_wr,
  output logic               pid_rd,
  output logic [BUS_W-1:0]   eng_wdata,
  output logic [BUS_W-1:0]   bus_ctl,
  output logic [BUS_W-1:0]   ctl2,
  output logic [BUS_W-1:0]   div_a,
  output logic [BUS_W-1:0]   div_b
);
  import mxb_pkg::*;

  localparam logic [BUS_W-1:0] EN_MASK = BUS_W'(INT_EN_MASK);

  logic [BUS_W-1:0]            addr_q;
  logic [NRW-1:0][BUS_W-1:0]   rw_q;
  logic [NRW-1:0]              we;
  logic [BUS_W-1:0]            rdata_q, wdata_q, rmux;
  logic                        card_wr_q, card_rd_q, pid_wr_q, pid_rd_q;
  logic                        hit_intc, hit_cdat, hit_pdat, hit_rev;

  for (genvar i = 0; i < NRW; i++) begin : g_we
    assign we[i] = data_wr && (addr_q == BUS_W'(RW_ADDR[i]));
  end

  assign hit_intc = (addr_q == BUS_W'(A_INTC));
  assign hit_cdat = (addr_q == BUS_W'(A_CDAT));
  assign hit_pdat = (addr_q == BUS_W'(A_PDAT));
  assign hit_rev  = (addr_q == BUS_W'(A_REV));

  always_comb begin
    rmux = '0;
    for (int i = 0; i < NRW; i++)
      if (addr_q == BUS_W'(RW_ADDR[i])) rmux = rw_q[i];
    if (hit_intc) rmux[0] = pending;
    if (hit_cdat) rmux = card_rdata;
    if (hit_pdat) rmux = pid_rdata;
    if (hit_rev)  rmux = REVISION;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      rw_q      <= '0;
      rdata_q   <= '0;
      wdata_q   <= '0;
      card_wr_q <= 1'b0;
      card_rd_q <= 1'b0;
      pid_wr_q  <= 1'b0;
      pid_rd_q  <= 1'b0;
    end else begin
      if (addr_wr) addr_q <= bus_d;
      for (int i = 0; i < NRW; i++)
        if (we[i]) rw_q[i] <= bus_d;
      if (data_rd) rdata_q <= rmux;
      if (data_wr && (hit_cdat || hit_pdat)) wdata_q <= bus_d;
      card_wr_q <= data_wr && hit_cdat;
      card_rd_q <= data_rd && hit_cdat;
      pid_wr_q  <= data_wr && hit_pdat;
      pid_rd_q  <= data_rd && hit_pdat;
    end
  end

  assign rdata     = rdata_q;
  assign irq_ack   = data_rd && hit_intc;
  assign irq_en    = (rw_q[IX_INTC] & EN_MASK) == EN_MASK;
  assign card_addr = {rw_q[IX_CADH], rw_q[IX_CADL]};
  assign pid_addr  = {rw_q[IX_PADH], rw_q[IX_PADL]};
  assign card_wr   = card_wr_q;
  assign card_rd   = card_rd_q;
  assign pid_wr    = pid_wr_q;
  assign pid_rd    = pid_rd_q;
  assign eng_wdata = wdata_q;
  assign bus_ctl   = rw_q[IX_BCTL];
  assign ctl2      = rw_q[IX_CTL2];
  assign div_a     = rw_q[IX_DIVA];
  assign div_b     = rw_q[IX_DIVB];
endmodule

// File: rtl/mxbus_slave.sv
module mxbus_slave #(
  parameter int               BUS_W       = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [BUS_W-1:0] REVISION    = BUS_W'(8'h2A)
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic [BUS_W-1:0]   bus_in,
  output logic [BUS_W-1:0]   bus_out,
  output logic               bus_oe,
  input  logic               ab_sel,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  output logic               rdy_n,
  output logic               irq_n,
  input  logic               evt_i,
  output logic [2*BUS_W-1:0] card_addr_o,
  output logic               card_wr_o,
  output logic               card_rd_o,
  input  logic [BUS_W-1:0]   card_rdata_i,
  output logic [2*BUS_W-1:0] pid_addr_o,
  output logic               pid_wr_o,
  output logic               pid_rd_o,
  input  logic [BUS_W-1:0]   pid_rdata_i,
  output logic [BUS_W-1:0]   eng_wdata_o,
  output logic [BUS_W-1:0]   bus_ctl_o,
  output logic [BUS_W-1:0]   ctl2_o,
  output logic [1:0]         ts_en_o,
  output logic [BUS_W-1:0]   div_a_o,
  output logic [BUS_W-1:0]   div_b_o
);
  import mxb_pkg::*;

  localparam int SW = BUS_W + 4;
  localparam logic [SW-1:0] IN_RST = {1'b0, 3'b111, {BUS_W{1'b0}}};

  logic             rst_n;
  logic [SW-1:0]    s_in;
  logic             addr_wr, data_wr, data_rd;
  logic             pending, irq_ack, irq_en;

  mxb_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(arst_n), .d(1'b1), .q(rst_n));

  mxb_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_in (
    .clk(clk), .rst_n(rst_n), .d({ab_sel, cs_n, rd_n, wr_n, bus_in}), .q(s_in));

  mxb_handshake u_hs (
    .clk(clk), .rst_n(rst_n),
    .s_cs_n(s_in[BUS_W+2]), .s_rd_n(s_in[BUS_W+1]), .s_wr_n(s_in[BUS_W]),
    .s_phase(s_in[BUS_W+3]),
    .addr_wr(addr_wr), .data_wr(data_wr), .data_rd(data_rd),
    .rdy_n(rdy_n), .oe(bus_oe));

  mxb_regfile #(.BUS_W(BUS_W), .REVISION(REVISION)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .addr_wr(addr_wr), .data_wr(data_wr), .data_rd(data_rd),
    .bus_d(s_in[BUS_W-1:0]), .pending(pending),
    .card_rdata(card_rdata_i), .pid_rdata(pid_rdata_i),
    .rdata(bus_out), .irq_ack(irq_ack), .irq_en(irq_en),
    .card_addr(card_addr_o), .pid_addr(pid_addr_o),
    .card_wr(card_wr_o), .card_rd(card_rd_o), .pid_wr(pid_wr_o), .pid_rd(pid_rd_o),
    .eng_wdata(eng_wdata_o), .bus_ctl(bus_ctl_o), .ctl2(ctl2_o),
    .div_a(div_a_o), .div_b(div_b_o));

  mxb_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .en(irq_en), .ack(irq_ack),
    .pending(pending), .irq_n(irq_n));

  assign ts_en_o = ctl2_o[TS_EN_LSB +: 2];
endmodule

// File: rtl/mxb_chk.sv
module mxb_chk #(
  parameter int LIM = 4
) (
  input logic clk,
  input logic arst_n,
  input logic cs_n,
  input logic rd_n,
  input logic wr_n,
  input logic rdy_n,
  input logic bus_oe,
  input logic irq_n,
  input logic evt_i,
  input logic irq_ack,
  input logic card_wr_o,
  input logic card_rd_o,
  input logic pid_wr_o,
  input logic pid_rd_o
);
  localparam int CW = $clog2(LIM + 2) + 1;
  localparam logic [CW-1:0] CMAX = CW'(LIM + 1);

  logic [CW-1:0] act_cnt;
  logic          host_act, any_eng;

  assign host_act = !cs_n && (!rd_n || !wr_n);
  assign any_eng  = card_wr_o || card_rd_o || pid_wr_o || pid_rd_o;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                          act_cnt <= '0;
    else if (!host_act)                   act_cnt <= '0;
    else if (act_cnt != CMAX)             act_cnt <= act_cnt + 1'b1;
  end

  // R7: a held strobe is answered within the bound
  assert_rdy_bounded_R7: assert property (@(posedge clk) disable iff (!arst_n)
    (act_cnt == CMAX) |-> !rdy_n);

  // R11: read data is only driven inside an acknowledged access
  assert_oe_in_ack_R11: assert property (@(posedge clk) disable iff (!arst_n)
    bus_oe |-> !rdy_n);

  // R8: the interrupt line only falls after an engine event
  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(irq_n) |-> $past(evt_i));

  // R9: the interrupt line only rises after an acknowledge read
  assert_irq_clr_R9: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(irq_n) |-> $past(irq_ack));

  // R4: engine strobes are exclusive and last a single cycle
  assert_eng_onehot_R4: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({card_wr_o, card_rd_o, pid_wr_o, pid_rd_o}));
  assert_eng_single_R4: assert property (@(posedge clk) disable iff (!arst_n)
    any_eng |=> !any_eng);
endmodule

bind mxbus_slave mxb_chk #(.LIM(SYNC_STAGES + 2)) u_chk (
  .clk(clk), .arst_n(arst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .rdy_n(rdy_n), .bus_oe(bus_oe), .irq_n(irq_n), .evt_i(evt_i),
  .irq_ack(irq_ack), .card_wr_o(card_wr_o), .card_rd_o(card_rd_o),
  .pid_wr_o(pid_wr_o), .pid_rd_o(pid_rd_o));

// File: tb/sim_mxbus_slave.sv
`timescale 1ns/1ps
module sim_mxbus_slave;
  localparam int         SYNC = 2;
  localparam int         LIM  = SYNC + 2;
  localparam logic [7:0] REV  = 8'hA7;
  localparam int         NV   = 24;
  // {is_read, address, write data, expected read data}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h01, 8'h35, 8'h00}, {1'b1, 8'h01, 8'h00, 8'h35},
    {1'b0, 8'h04, 8'hA5, 8'h00}, {1'b0, 8'h05, 8'h3C, 8'h00},
    {1'b1, 8'h04, 8'h00, 8'hA5}, {1'b1, 8'h05, 8'h00, 8'h3C},
    {1'b0, 8'h07, 8'h81, 8'h00}, {1'b1, 8'h07, 8'h00, 8'h81},
    {1'b0, 8'h08, 8'h12, 8'h00}, {1'b0, 8'h09, 8'h03, 8'h00},
    {1'b1, 8'h08, 8'h00, 8'h12}, {1'b1, 8'h09, 8'h00, 8'h03},
    {1'b0, 8'h0C, 8'h07, 8'h00}, {1'b0, 8'h0D, 8'h0E, 8'h00},
    {1'b1, 8'h0C, 8'h00, 8'h07}, {1'b1, 8'h0D, 8'h00, 8'h0E},
    {1'b1, 8'h0F, 8'h00, REV  }, {1'b0, 8'h0F, 8'h55, 8'h00},
    {1'b1, 8'h0F, 8'h00, REV  }, {1'b1, 8'h02, 8'h00, 8'h00},
    {1'b1, 8'h0B, 8'h00, 8'h00}, {1'b0, 8'h03, 8'hFF, 8'h00},
    {1'b0, 8'h0E, 8'hFF, 8'h00}, {1'b1, 8'h0E, 8'h00, 8'h00}};

  logic        clk = 1'b0;
  logic        arst_n, ab_sel, cs_n, rd_n, wr_n, evt_i;
  logic [7:0]  bus_in, card_rdata_i, pid_rdata_i;
  logic [7:0]  bus_out, eng_wdata_o, bus_ctl_o, ctl2_o, div_a_o, div_b_o;
  logic [15:0] card_addr_o, pid_addr_o;
  logic [1:0]  ts_en_o;
  logic        bus_oe, rdy_n, irq_n, card_wr_o, card_rd_o, pid_wr_o, pid_rd_o;

  int nchk = 0, nfail = 0;
  int max_lat = 0, hold_extra = 0;
  int n_cwr = 0, n_crd = 0, n_pwr = 0, n_prd = 0;
  logic [7:0] last_wd = 8'h00;

  always #4 clk = ~clk;

  mxbus_slave #(.BUS_W(8), .SYNC_STAGES(SYNC), .REVISION(REV)) u0 (
    .clk(clk), .arst_n(arst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .ab_sel(ab_sel), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .rdy_n(rdy_n),
    .irq_n(irq_n), .evt_i(evt_i), .card_addr_o(card_addr_o), .card_wr_o(card_wr_o),
    .card_rd_o(card_rd_o), .card_rdata_i(card_rdata_i), .pid_addr_o(pid_addr_o),
    .pid_wr_o(pid_wr_o), .pid_rd_o(pid_rd_o), .pid_rdata_i(pid_rdata_i),
    .eng_wdata_o(eng_wdata_o), .bus_ctl_o(bus_ctl_o), .ctl2_o(ctl2_o),
    .ts_en_o(ts_en_o), .div_a_o(div_a_o), .div_b_o(div_b_o));

  always @(negedge clk) begin
    if (card_wr_o) begin n_cwr++; last_wd = eng_wdata_o; end
    if (pid_wr_o)  begin n_pwr++; last_wd = eng_wdata_o; end
    if (card_rd_o) n_crd++;
    if (pid_rd_o)  n_prd++;
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic ph, input logic rd, input logic [7:0] wd,
                      output logic [7:0] rv, output logic oe_seen);
    int lat, rl;
    @(negedge clk);
    bus_in = wd; ab_sel = ph;
    @(negedge clk);
    cs_n = 1'b0;
    if (rd) rd_n = 1'b0; else wr_n = 1'b0;
    lat = 0;
    while (rdy_n && lat < 20) begin @(negedge clk); lat++; end
    if (lat > max_lat) max_lat = lat;
    rv = bus_out; oe_seen = bus_oe;
    repeat (hold_extra) @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    rl = 0;
    while (!rdy_n && rl < 20) begin @(negedge clk); rl++; end
    if (rl > max_lat) max_lat = rl;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, output logic oe_seen);
    logic [7:0] rv; logic oe1;
    xfer(1'b1, 1'b0, a, rv, oe1);
    xfer(1'b0, 1'b0, d, rv, oe_seen);
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] rv; logic oe1, oe2;
    xfer(1'b1, 1'b0, a, rv, oe1);
    xfer(1'b0, 1'b1, 8'h00, v, oe2);
  endtask

  task automatic pulse_evt();
    @(negedge clk); evt_i = 1'b1;
    @(negedge clk); evt_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h0F) return "R5";
    if (a == 8'h02 || a == 8'h03 || a == 8'h0B || a == 8'h0E) return "R6";
    return "R3";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R7 watchdog expired: got %h expected %h", 1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v, v2; logic oe; int bad;
    arst_n = 1'b0; ab_sel = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    bus_in = 8'h00; evt_i = 1'b0; card_rdata_i = 8'hC3; pid_rdata_i = 8'h5E;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "rdy_n in reset", {15'd0, rdy_n}, 16'd1);
    chk("R1", "irq_n in reset", {15'd0, irq_n}, 16'd1);
    chk("R1", "bus_oe in reset", {15'd0, bus_oe}, 16'd0);
    chk("R1", "address outputs in reset", card_addr_o | pid_addr_o, 16'd0);
    chk("R1", "control outputs in reset",
        {8'd0, bus_ctl_o | ctl2_o | div_a_o | div_b_o | {6'd0, ts_en_o}}, 16'd0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        rd_reg(VEC[i][23:16], v);
        chk(tag_of(VEC[i][23:16]), $sformatf("read of %h", VEC[i][23:16]),
            {8'd0, v}, {8'd0, VEC[i][7:0]});
      end else begin
        wr_reg(VEC[i][23:16], VEC[i][15:8], oe);
        chk("R11", "bus_oe during write ack", {15'd0, oe}, 16'd0);
      end
    end
    chk("R3", "card_addr_o", card_addr_o, 16'h3CA5);
    chk("R3", "pid_addr_o", pid_addr_o, 16'h0312);
    chk("R6", "outputs after undefined writes",
        {bus_ctl_o, ctl2_o}, 16'h8135);
    chk("R6", "dividers after undefined writes", {div_a_o, div_b_o}, 16'h070E);
    chk("R10", "ts_en_o from 0x35", {14'd0, ts_en_o}, 16'd3);

    // R2 address cycle changes nothing and persists
    xfer(1'b1, 1'b0, 8'h07, v, oe);
    chk("R2", "bus_ctl_o after address cycle", {8'd0, bus_ctl_o}, 16'h0081);
    xfer(1'b0, 1'b0, 8'h5A, v, oe);
    xfer(1'b0, 1'b1, 8'h00, v, oe);
    chk("R11", "bus_oe during read ack", {15'd0, oe}, 16'd1);
    xfer(1'b0, 1'b1, 8'h00, v2, oe);
    chk("R2", "first data read without new address", {8'd0, v}, 16'h005A);
    chk("R2", "second data read without new address", {8'd0, v2}, 16'h005A);

    // R4 engine ports with held strobes
    hold_extra = 6;
    wr_reg(8'h06, 8'h77, oe);
    chk("R4", "card write pulses", n_cwr[15:0], 16'd1);
    chk("R4", "card write data", {8'd0, last_wd}, 16'h0077);
    rd_reg(8'h06, v);
    chk("R4", "card read data", {8'd0, v}, 16'h00C3);
    chk("R4", "card read pulses", n_crd[15:0], 16'd1);
    wr_reg(8'h0A, 8'h99, oe);
    rd_reg(8'h0A, v);
    chk("R4", "pid read data", {8'd0, v}, 16'h005E);
    chk("R4", "pid pulses wr/rd", {n_pwr[7:0], n_prd[7:0]}, 16'h0101);
    chk("R4", "pid write data", {8'd0, last_wd}, 16'h0099);
    chk("R7", "card pulses unchanged under held strobes", {n_cwr[7:0], n_crd[7:0]}, 16'h0101);
    hold_extra = 0;

    // R12 strobes without chip select
    xfer(1'b1, 1'b0, 8'h07, v, oe);
    @(negedge clk);
    ab_sel = 1'b0; bus_in = 8'hEE; wr_n = 1'b0;
    bad = 0;
    repeat (12) begin @(negedge clk); if (!rdy_n) bad++; end
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", "rdy_n low cycles without cs_n", bad[15:0], 16'd0);
    chk("R12", "bus_ctl_o without cs_n", {8'd0, bus_ctl_o}, 16'h005A);

    // R8 interrupt enable needs both bits
    pulse_evt();
    chk("R8", "irq_n with enables clear", {15'd0, irq_n}, 16'd1);
    wr_reg(8'h00, 8'h04, oe);
    pulse_evt();
    chk("R8", "irq_n with partial enable", {15'd0, irq_n}, 16'd1);
    wr_reg(8'h00, 8'h44, oe);
    pulse_evt();
    chk("R8", "irq_n with full enable", {15'd0, irq_n}, 16'd0);

    // R9 acknowledge by reading the interrupt register
    rd_reg(8'h00, v);
    chk("R9", "interrupt register with pending", {8'd0, v}, 16'h0045);
    chk("R9", "irq_n after acknowledge", {15'd0, irq_n}, 16'd1);
    rd_reg(8'h00, v);
    chk("R9", "interrupt register after acknowledge", {8'd0, v}, 16'h0044);

    // R10 stream enables follow bus control 2
    wr_reg(8'h01, 8'h10, oe);
    chk("R10", "ts_en_o from 0x10", {14'd0, ts_en_o}, 16'd1);

    // R7 handshake latency across every access
    chk("R7", "worst ready latency within bound", {15'd0, max_lat <= LIM}, 16'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule